// File: doc/BRIEF.md
# Pipelined Table-Interpolated Reciprocal Unit

This block approximates 1/x for an unsigned 16-bit operand and takes a new operand on every clock, with no stalls. It first removes the operand's trailing zero bits and counts them. The remaining odd value is then split into an 8-bit index (its top bits) and a remainder (the bits below the index). Two constant tables are read at the index: one holds 1/a and the other holds 1/a². A first-order correction is formed from the squared-reciprocal entry, the remainder and a subtract. A final shift with rounding restores the scale that the trim and the split removed.

The result is an unsigned fixed-point value with 24 fractional bits and one integer bit, so an input of 1 gives exactly 1.0. A build-time parameter can add one Newton-Raphson refinement step, r·(2 − r·x). The step is applied to the unscaled intermediate value and adds two pipeline stages. A zero operand gives an all-ones output and raises a divide-by-zero flag on the same cycle. The block is meant to feed a multiplier that turns a reciprocal into a quotient. A valid bit travels with each operand through the pipeline.

Top module: `recip_unit`

## Requirements
- R1: An operand accepted with `in_valid` high appears on `out_valid` exactly 4 clocks later when `REFINE` = 0, and exactly 6 clocks later when `REFINE` = 1. Back-to-back operands give back-to-back results in the same order, one per clock.
- R2: For an operand of 0, the output is all ones and `out_dz` = 1. For every nonzero operand, `out_dz` = 0.
- R3: For x = 2^k (k = 0..15), the output is exactly 2^(24−k). For x = 1 this is 0x1000000, which is 1.0.
- R4: With `REFINE` = 0, every x from 1 to 65535 satisfies |out·x − 2^24| ≤ 255·x. This means the absolute error in output units is at most 255/2^24, so the error times 65535 stays below one integer unit.
- R5: With `REFINE` = 1, every x from 1 to 65535 satisfies |out·x − 2^24| ≤ 3·x, which is at most 3 output LSBs.
- R6: With `REFINE` = 0, take x = a·2^m with a odd and a < 256. The output is E rounded half-up after a right shift by m, where E = floor((2^24 + floor(a/2)) / a), the stored table entry for a.
- R7: Whenever `out_valid` is 0, `out_recip` = 0 and `out_dz` = 0. This includes the cycles right after reset.
- R8: Every non-zero-operand result is no larger than 0x1000000 (1.0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand present this cycle |
| in_x | input | IN_W (16) | Unsigned operand |
| out_valid | output | 1 | Result present this cycle |
| out_recip | output | FRAC_W+1 (25) | Reciprocal, unsigned, 24 fractional bits |
| out_dz | output | 1 | Operand was zero; output saturated |

## Verification
Each internal fault shows up at a distinct place in the outputs.
- A wrong trailing-zero count or split point shows up at once on the result of that operand as a power-of-two scale error. Powers of two and small odd multiples expose it exactly.
- A corrupted table entry or correction term stays confined to operands whose index hits that entry. For this reason every operand from 1 to 65535 is pushed through both build variants.
- A misaligned valid or zero flag appears as a result on the wrong cycle, or as a saturated value attached to a nonzero operand. It is caught by the latency and count checks within a handful of clocks.

// File: rtl/recip_pkg.sv
package recip_pkg;

  // Rounded fixed-point value of 1/den with frac_bits fractional bits; 0 for den = 0.
  function automatic logic [63:0] recip_entry(input int frac_bits, input logic [63:0] den);
    logic [63:0] num;
    if (den == 64'd0) return 64'd0;
    num = 64'd1 << frac_bits;
    return (num + (den >> 1)) / den;
  endfunction

endpackage

// File: rtl/recip_trim.sv
module recip_trim #(
  parameter int IN_W  = 16,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_x,
  output logic             s1_valid,
  output logic             s1_zero,
  output logic [CNT_W-1:0] s1_m,
  output logic [IN_W-1:0]  s1_t
);
  logic [CNT_W-1:0] tz_c;

  // Lowest set bit wins: scan from the top so the last hit is the lowest.
  always_comb begin
    tz_c = '0;
    for (int i = IN_W - 1; i >= 0; i--) begin
      if (in_x[i]) tz_c = CNT_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_zero  <= 1'b0;
      s1_m     <= '0;
      s1_t     <= '0;
    end else begin
      s1_valid <= in_valid;
      s1_zero  <= (in_x == '0);
      s1_m     <= tz_c;
      s1_t     <= in_x >> tz_c;
    end
  end
endmodule

// File: rtl/recip_rom.sv
module recip_rom #(
  parameter int IDX_W  = 8,
  parameter int FRAC_W = 24,
  parameter int TAB_W  = 25,
  parameter bit SQUARE = 1'b0
) (
  input  logic             clk,
  input  logic [IDX_W-1:0] addr,
  output logic [TAB_W-1:0] q
);
  localparam int DEPTH = 1 << IDX_W;

  logic [TAB_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = TAB_W'(recip_pkg::recip_entry(FRAC_W, 64'(SQUARE ? i * i : i)));
    end
  end

  // Registered read, no reset: maps onto a block RAM in ROM mode.
  always_ff @(posedge clk) begin
    q <= mem[addr];
  end
endmodule

// File: rtl/recip_lookup.sv
module recip_lookup #(
  parameter int IN_W   = 16,
  parameter int FRAC_W = 24,
  parameter int IDX_W  = 8,
  parameter int CNT_W  = 5,
  parameter int TAB_W  = 25
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             s1_valid,
  input  logic             s1_zero,
  input  logic [CNT_W-1:0] s1_m,
  input  logic [IN_W-1:0]  s1_t,
  output logic             s2_valid,
  output logic             s2_zero,
  output logic [CNT_W-1:0] s2_m,
  output logic [CNT_W-1:0] s2_n,
  output logic [IN_W-1:0]  s2_b,
  output logic [IN_W-1:0]  s2_t,
  output logic [TAB_W-1:0] s2_ta,
  output logic [TAB_W-1:0] s2_tb
);
  logic [CNT_W-1:0] len_c;
  logic [CNT_W-1:0] n_c;
  logic [IDX_W-1:0] idx_c;
  logic [IN_W-1:0]  rem_c;

  always_comb begin
    len_c = '0;
    for (int i = 0; i < IN_W; i++) begin
      if (s1_t[i]) len_c = CNT_W'(i + 1);
    end
    n_c   = (len_c > CNT_W'(IDX_W)) ? (len_c - CNT_W'(IDX_W)) : '0;
    idx_c = IDX_W'(s1_t >> n_c);
    rem_c = s1_t & ((IN_W'(1) << n_c) - IN_W'(1));
  end

  recip_rom #(.IDX_W(IDX_W), .FRAC_W(FRAC_W), .TAB_W(TAB_W), .SQUARE(1'b0)) u_rom_inv (
    .clk (clk), .addr(idx_c), .q(s2_ta)
  );

  recip_rom #(.IDX_W(IDX_W), .FRAC_W(FRAC_W), .TAB_W(TAB_W), .SQUARE(1'b1)) u_rom_sq (
    .clk (clk), .addr(idx_c), .q(s2_tb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_valid <= 1'b0;
      s2_zero  <= 1'b0;
      s2_m     <= '0;
      s2_n     <= '0;
      s2_b     <= '0;
      s2_t     <= '0;
    end else begin
      s2_valid <= s1_valid;
      s2_zero  <= s1_zero;
      s2_m     <= s1_m;
      s2_n     <= n_c;
      s2_b     <= rem_c;
      s2_t     <= s1_t;
    end
  end
endmodule

// File: rtl/recip_interp.sv
module recip_interp #(
  parameter int IN_W  = 16,
  parameter int CNT_W = 5,
  parameter int TAB_W = 25
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             s2_valid,
  input  logic             s2_zero,
  input  logic [CNT_W-1:0] s2_m,
  input  logic [CNT_W-1:0] s2_n,
  input  logic [IN_W-1:0]  s2_b,
  input  logic [IN_W-1:0]  s2_t,
  input  logic [TAB_W-1:0] s2_ta,
  input  logic [TAB_W-1:0] s2_tb,
  output logic             s3_valid,
  output logic             s3_zero,
  output logic [CNT_W-1:0] s3_m,
  output logic [CNT_W-1:0] s3_n,
  output logic [IN_W-1:0]  s3_t,
  output logic [TAB_W-1:0] s3_d
);
  localparam int P_W = TAB_W + IN_W;

  logic [P_W-1:0]   prod_c;
  logic [TAB_W-1:0] d_c;

  // d = A[a] - B[a] * b / 2^n
  always_comb begin
    prod_c = P_W'(s2_tb) * P_W'(s2_b);
    d_c    = s2_ta - TAB_W'(prod_c >> s2_n);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s3_valid <= 1'b0;
      s3_zero  <= 1'b0;
      s3_m     <= '0;
      s3_n     <= '0;
      s3_t     <= '0;
      s3_d     <= '0;
    end else begin
      s3_valid <= s2_valid;
      s3_zero  <= s2_zero;
      s3_m     <= s2_m;
      s3_n     <= s2_n;
      s3_t     <= s2_t;
      s3_d     <= d_c;
    end
  end
endmodule

// File: rtl/recip_refine.sv
module recip_refine #(
  parameter int IN_W   = 16,
  parameter int FRAC_W = 24,
  parameter int CNT_W  = 5,
  parameter int TAB_W  = 25
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             i_valid,
  input  logic             i_zero,
  input  logic [CNT_W-1:0] i_m,
  input  logic [CNT_W-1:0] i_n,
  input  logic [IN_W-1:0]  i_t,
  input  logic [TAB_W-1:0] i_d,
  output logic             o_valid,
  output logic             o_zero,
  output logic [CNT_W-1:0] o_m,
  output logic [CNT_W-1:0] o_n,
  output logic [TAB_W-1:0] o_d
);
  localparam int P_W = TAB_W + IN_W;
  localparam int E_W = FRAC_W + 2;
  localparam int Q_W = TAB_W + E_W;
  localparam logic [P_W-1:0]   TWO  = P_W'(1) << (FRAC_W + 1);
  localparam logic [TAB_W-1:0] DMAX = '1;

  logic [P_W-1:0]   rx_c;
  logic [E_W-1:0]   e_c;
  logic             r1_valid, r1_zero;
  logic [CNT_W-1:0] r1_m, r1_n;
  logic [TAB_W-1:0] r1_d;
  logic [E_W-1:0]   r1_e;
  logic [Q_W-1:0]   q_c;
  logic [TAB_W-1:0] dn_c;

  // First half: e = 2 - d * (t / 2^n), with d and the value 1.0 at scale 2^FRAC_W.
  always_comb begin
    rx_c = (P_W'(i_d) * P_W'(i_t)) >> i_n;
    e_c  = E_W'(TWO - rx_c);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      r1_valid <= 1'b0;
      r1_zero  <= 1'b0;
      r1_m     <= '0;
      r1_n     <= '0;
      r1_d     <= '0;
      r1_e     <= '0;
    end else begin
      r1_valid <= i_valid;
      r1_zero  <= i_zero;
      r1_m     <= i_m;
      r1_n     <= i_n;
      r1_d     <= i_d;
      r1_e     <= e_c;
    end
  end

  // Second half: d' = d * e, rescaled and clamped to the table width.
  always_comb begin
    q_c  = (Q_W'(r1_d) * Q_W'(r1_e)) >> FRAC_W;
    dn_c = (q_c > Q_W'(DMAX)) ? DMAX : TAB_W'(q_c);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      o_valid <= 1'b0;
      o_zero  <= 1'b0;
      o_m     <= '0;
      o_n     <= '0;
      o_d     <= '0;
    end else begin
      o_valid <= r1_valid;
      o_zero  <= r1_zero;
      o_m     <= r1_m;
      o_n     <= r1_n;
      o_d     <= dn_c;
    end
  end
endmodule

// File: rtl/recip_scale.sv
module recip_scale #(
  parameter int CNT_W = 5,
  parameter int TAB_W = 25
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             f_valid,
  input  logic             f_zero,
  input  logic [CNT_W-1:0] f_m,
  input  logic [CNT_W-1:0] f_n,
  input  logic [TAB_W-1:0] f_d,
  output logic             out_valid,
  output logic [TAB_W-1:0] out_recip,
  output logic             out_dz
);
  logic [CNT_W:0] sh_c;
  logic [TAB_W:0] rnd_c, sum_c, res_c;

  // Round half-up while shifting right by m + n.
  always_comb begin
    sh_c  = {1'b0, f_m} + {1'b0, f_n};
    rnd_c = (sh_c == '0) ? '0 : ((TAB_W + 1)'(1) << (sh_c - (CNT_W + 1)'(1)));
    sum_c = {1'b0, f_d} + rnd_c;
    res_c = sum_c >> sh_c;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_dz    <= 1'b0;
      out_recip <= '0;
    end else begin
      out_valid <= f_valid;
      out_dz    <= f_valid && f_zero;
      if (!f_valid)                out_recip <= '0;
      else if (f_zero || res_c[TAB_W]) out_recip <= '1;
      else                         out_recip <= res_c[TAB_W-1:0];
    end
  end
endmodule

// File: rtl/recip_unit.sv
module recip_unit #(
  parameter int IN_W   = 16,
  parameter int FRAC_W = 24,
  parameter int IDX_W  = 8,
  parameter bit REFINE = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [IN_W-1:0]   in_x,
  output logic              out_valid,
  output logic [FRAC_W:0]   out_recip,
  output logic              out_dz
);
  localparam int CNT_W = $clog2(IN_W + 1);
  localparam int TAB_W = FRAC_W + 1;

  logic             s1_valid, s1_zero;
  logic [CNT_W-1:0] s1_m;
  logic [IN_W-1:0]  s1_t;

  logic             s2_valid, s2_zero;
  logic [CNT_W-1:0] s2_m, s2_n;
  logic [IN_W-1:0]  s2_b, s2_t;
  logic [TAB_W-1:0] s2_ta, s2_tb;

  logic             s3_valid, s3_zero;
  logic [CNT_W-1:0] s3_m, s3_n;
  logic [IN_W-1:0]  s3_t;
  logic [TAB_W-1:0] s3_d;

  logic             f_valid, f_zero;
  logic [CNT_W-1:0] f_m, f_n;
  logic [TAB_W-1:0] f_d;

  recip_trim #(.IN_W(IN_W), .CNT_W(CNT_W)) u_trim (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_x(in_x),
    .s1_valid(s1_valid), .s1_zero(s1_zero), .s1_m(s1_m), .s1_t(s1_t)
  );

  recip_lookup #(.IN_W(IN_W), .FRAC_W(FRAC_W), .IDX_W(IDX_W), .CNT_W(CNT_W), .TAB_W(TAB_W)) u_lookup (
    .clk(clk), .rst(rst),
    .s1_valid(s1_valid), .s1_zero(s1_zero), .s1_m(s1_m), .s1_t(s1_t),
    .s2_valid(s2_valid), .s2_zero(s2_zero), .s2_m(s2_m), .s2_n(s2_n),
    .s2_b(s2_b), .s2_t(s2_t), .s2_ta(s2_ta), .s2_tb(s2_tb)
  );

  recip_interp #(.IN_W(IN_W), .CNT_W(CNT_W), .TAB_W(TAB_W)) u_interp (
    .clk(clk), .rst(rst),
    .s2_valid(s2_valid), .s2_zero(s2_zero), .s2_m(s2_m), .s2_n(s2_n),
    .s2_b(s2_b), .s2_t(s2_t), .s2_ta(s2_ta), .s2_tb(s2_tb),
    .s3_valid(s3_valid), .s3_zero(s3_zero), .s3_m(s3_m), .s3_n(s3_n),
    .s3_t(s3_t), .s3_d(s3_d)
  );

  generate
    if (REFINE) begin : g_refine
      recip_refine #(.IN_W(IN_W), .FRAC_W(FRAC_W), .CNT_W(CNT_W), .TAB_W(TAB_W)) u_refine (
        .clk(clk), .rst(rst),
        .i_valid(s3_valid), .i_zero(s3_zero), .i_m(s3_m), .i_n(s3_n), .i_t(s3_t), .i_d(s3_d),
        .o_valid(f_valid), .o_zero(f_zero), .o_m(f_m), .o_n(f_n), .o_d(f_d)
      );
    end else begin : g_direct
      logic unused_t;
      assign unused_t = ^s3_t;
      assign f_valid  = s3_valid;
      assign f_zero   = s3_zero;
      assign f_m      = s3_m;
      assign f_n      = s3_n;
      assign f_d      = s3_d;
    end
  endgenerate

  recip_scale #(.CNT_W(CNT_W), .TAB_W(TAB_W)) u_scale (
    .clk(clk), .rst(rst),
    .f_valid(f_valid), .f_zero(f_zero), .f_m(f_m), .f_n(f_n), .f_d(f_d),
    .out_valid(out_valid), .out_recip(out_recip), .out_dz(out_dz)
  );
endmodule

// File: rtl/recip_unit_chk.sv
module recip_unit_chk #(
  parameter int IN_W   = 16,
  parameter int FRAC_W = 24,
  parameter bit REFINE = 1'b0
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic [IN_W-1:0] in_x,
  input logic            out_valid,
  input logic [FRAC_W:0] out_recip,
  input logic            out_dz
);
  localparam int LAT = REFINE ? 6 : 4;
  localparam logic [FRAC_W:0] ONE = (FRAC_W + 1)'(1) << FRAC_W;

  logic [3:0] age;
  always_ff @(posedge clk) begin
    if (rst)              age <= '0;
    else if (age != 4'hF) age <= age + 4'd1;
  end

  p_latency_r1: assert property (@(posedge clk) disable iff (rst)
    (age >= 4'(LAT)) |-> (out_valid == $past(in_valid, LAT)));

  p_zero_flag_r2: assert property (@(posedge clk) disable iff (rst)
    (age >= 4'(LAT) && $past(in_valid, LAT)) |-> (out_dz == ($past(in_x, LAT) == '0)));

  p_zero_sat_r2: assert property (@(posedge clk) disable iff (rst)
    out_dz |-> (out_valid && (&out_recip)));

  p_unity_r3: assert property (@(posedge clk) disable iff (rst)
    (age >= 4'(LAT) && $past(in_valid, LAT) && $past(in_x, LAT) == IN_W'(1)) |-> (out_recip == ONE));

  p_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (out_recip == '0 && !out_dz));

  p_range_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_dz) |-> (out_recip <= ONE));
endmodule

bind recip_unit recip_unit_chk #(.IN_W(IN_W), .FRAC_W(FRAC_W), .REFINE(REFINE)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_x(in_x),
  .out_valid(out_valid), .out_recip(out_recip), .out_dz(out_dz)
);

// File: tb/sim_recip_unit.sv
module sim_recip_unit;
  localparam int IN_W   = 16;
  localparam int FRAC_W = 24;
  localparam int OUT_W  = FRAC_W + 1;
  localparam logic [OUT_W-1:0] ONE = OUT_W'(1) << FRAC_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [IN_W-1:0] in_x = '0;
  logic v0, z0, v1, z1;
  logic [OUT_W-1:0] r0, r1;

  always #10 clk = ~clk;

  recip_unit #(.REFINE(1'b0)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_x(in_x),
    .out_valid(v0), .out_recip(r0), .out_dz(z0)
  );

  recip_unit #(.REFINE(1'b1)) u1 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_x(in_x),
    .out_valid(v1), .out_recip(r1), .out_dz(z1)
  );

  int tests = 0, fails = 0;
  bit done = 1'b0;
  logic [IN_W-1:0] ring [16];
  int wr = 0, rd0 = 0, rd1 = 0, sent = 0, got0 = 0, got1 = 0;

  function automatic int ctz(input logic [IN_W-1:0] x);
    for (int i = 0; i < IN_W; i++) if (x[i]) return i;
    return 0;
  endfunction

  task automatic report(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_out(input int which, input logic [IN_W-1:0] x,
                           input logic [OUT_W-1:0] r, input logic dz);
    longint err, lim, a, ea;
    int m;
    if (x == '0) begin
      report(dz && (r == '1), "R2", "zero operand {dz,recip}",
             longint'({dz, r}), longint'({1'b1, {OUT_W{1'b1}}}));
      return;
    end
    report(!dz, "R2", "flag on nonzero operand", longint'(dz), 0);
    err = longint'(r) * longint'(x) - (64'sd1 <<< FRAC_W);
    if (err < 0) err = -err;
    lim = (which == 0) ? 255 * longint'(x) : 3 * longint'(x);
    report(err <= lim, (which == 0) ? "R4" : "R5", "scaled error vs bound", err, lim);
    m = ctz(x);
    if ((x >> m) == 1) begin
      report(r == (ONE >> m), "R3", "power of two", longint'(r), longint'(ONE >> m));
    end else if (which == 0 && (x >> m) < 256) begin
      a  = longint'(x >> m);
      ea = ((64'sd1 <<< FRAC_W) + a / 2) / a;
      if (m > 0) ea = (ea + (64'sd1 <<< (m - 1))) >>> m;
      report(longint'(r) == ea, "R6", "single-entry operand", longint'(r), ea);
    end
  endtask

  task automatic send(input bit v, input logic [IN_W-1:0] x);
    @(negedge clk);
    in_valid = v;
    in_x     = x;
    if (v) begin
      ring[wr] = x;
      wr = (wr + 1) % 16;
      sent++;
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (v0) begin check_out(0, ring[rd0], r0, z0); rd0 = (rd0 + 1) % 16; got0++; end
      if (v1) begin check_out(1, ring[rd1], r1, z1); rd1 = (rd1 + 1) % 16; got1++; end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog run did not finish actual=%0d expected=%0d", sent, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int lat0, lat1;
    logic [IN_W-1:0] dir [14];
    void'($urandom(32'd5171));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R7: idle outputs after reset
    report(!v0 && r0 == '0 && !z0, "R7", "reset state u0", longint'({v0, z0, r0}), 0);
    report(!v1 && r1 == '0 && !z1, "R7", "reset state u1", longint'({v1, z1, r1}), 0);

    // R1: latency of an isolated operand
    send(1'b1, 16'd7);
    lat0 = 0;
    lat1 = 0;
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      if (k == 1) in_valid = 1'b0;
      if (v0 && lat0 == 0) lat0 = k;
      if (v1 && lat1 == 0) lat1 = k;
    end
    report(lat0 == 4, "R1", "latency without refinement", lat0, 4);
    report(lat1 == 6, "R1", "latency with refinement", lat1, 6);

    // Directed corners
    dir = '{16'd0, 16'd1, 16'd2, 16'h8000, 16'hFFFF, 16'd514, 16'd33008,
            16'd255, 16'd256, 16'd257, 16'h7F80, 16'h6000, 16'hFFFE, 16'd0};
    foreach (dir[i]) send(1'b1, dir[i]);
    repeat (8) send(1'b0, '0);

    // Every operand, back to back (R4, R5, R1 throughput)
    for (int x = 1; x <= 65535; x++) send(1'b1, IN_W'(x));
    repeat (8) send(1'b0, '0);
    report(got0 == sent, "R1", "result count u0 after stream", got0, sent);
    report(got1 == sent, "R1", "result count u1 after stream", got1, sent);

    // Random mix with gaps
    for (int i = 0; i < 3000; i++) begin
      int cls;
      logic [IN_W-1:0] x;
      cls = int'($urandom % 5);
      case (cls)
        0: x = IN_W'($urandom);
        1: x = IN_W'($urandom % 256);
        2: x = IN_W'((($urandom % 128) * 2 + 1) << ($urandom % 9));
        3: x = IN_W'(1) << ($urandom % 16);
        default: x = ($urandom % 8 == 0) ? '0 : IN_W'($urandom);
      endcase
      send(($urandom % 4) != 0, x);
    end
    repeat (10) send(1'b0, '0);
    report(got0 == sent, "R1", "result count u0 after random", got0, sent);
    report(got1 == sent, "R1", "result count u1 after random", got1, sent);
    report(!v0 && r0 == '0 && !z0, "R7", "idle after drain u0", longint'({v0, z0, r0}), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule